// File: doc/BRIEF.md
# Shared Multichannel FIFO Partitioner

This block is a buffer on the peripheral side. It holds one storage array and divides it among several channels that work independently of each other. Each channel is given its own slice of the array, described by a start offset and a length. Inside that slice the channel acts as a circular FIFO. A single push port and a single pop port, each with a channel select, move words in and out.

The DMA controller receives only two strobes per channel, each one cycle wide: one for every word written into that channel and one for every word read out of it. The DMA side keeps its own count of these strobes and decides from that count when to move data. No threshold or level is sent to it.

Software sets up a slice while the channel is idle and then enables the channel. It must keep slices from overlapping and keep each slice inside the array.

Top module: `shared_fifo_part`

## Requirements
- R1: After reset every channel is disabled. All `empty_o` bits read 1. All `full_o`, `err_o`, `wr_stb_o` and `rd_stb_o` bits read 0. Every level field reads 0.
- R2: A configuration write to a disabled channel loads its offset and length and clears its pointers, level and error bit. It enables the channel when `cfg_en_i` is 1 and the length is nonzero. If the length is zero the channel stays disabled.
- R3: A configuration write to an enabled channel with `cfg_en_i`=1 leaves the offset, length and contents unchanged. A write with `cfg_en_i`=0 disables the channel and flushes it to level 0. Any push or pop on that channel in the same cycle is dropped.
- R4: Words leave a channel in the order they entered. `pop_data_o` shows the head word of the channel chosen by `pop_ch_i` in the same cycle, without waiting for a clock edge.
- R5: Channel c stores word k of its slice at array address offset+k. After the last address, offset+length-1, the pointer returns to the offset. Traffic on one channel never changes the data held by another channel.
- R6: `level_o[c*SW +: SW]` gives the number of words held, where SW = log2(DEPTH)+1. `full_o[c]` is 1 when the level equals the length. `empty_o[c]` is 1 when the level is 0. These outputs update on the clock edge that accepts the operation.
- R7: A push to a full channel, or a pop from an empty one, is dropped and leaves the level unchanged. It sets `err_o[c]`. That bit stays set until the next configuration write accepted while the channel is disabled.
- R8: Each accepted push pulses `wr_stb_o[c]`, and each accepted pop pulses `rd_stb_o[c]`. The pulse lasts exactly one cycle and starts on the edge that accepts the word. A dropped operation gives no pulse.
- R9: A push or pop to a disabled channel is dropped. It gives no strobe and does not set the error bit.
- R10: A push and a pop to the same enabled channel in one cycle, when that channel is neither full nor empty, are both accepted. The level stays the same and both strobes pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ch_i | input | CW | Channel being configured |
| cfg_en_i | input | 1 | Enable value carried by the write |
| cfg_base_i | input | AW | Start offset of the slice |
| cfg_size_i | input | SW | Length of the slice in words |
| push_i | input | 1 | Push request |
| push_ch_i | input | CW | Channel to push into |
| push_data_i | input | DW | Word to push |
| pop_i | input | 1 | Pop request |
| pop_ch_i | input | CW | Channel to pop from; also selects `pop_data_o` |
| pop_data_o | output | DW | Head word of the channel selected by `pop_ch_i` |
| full_o | output | NCH | Full flag for each channel |
| empty_o | output | NCH | Empty flag for each channel |
| level_o | output | NCH*SW | Packed word count for each channel |
| err_o | output | NCH | Sticky error for an overflow or underflow attempt |
| wr_stb_o | output | NCH | One pulse for each word written |
| rd_stb_o | output | NCH | One pulse for each word read |

## Verification
`pop_data_o` is combinational, so the bench reads it 1 ns after it drives the pop, before the clock edge that consumes the word. Level, flags, error bits and both strobes are all registered. They change on the next rising edge, so the bench reads them at the falling edge that follows. At that moment the strobe from the operation is still high, and it drops one edge later. Configuration results are read one falling edge after the write, which fits the single register stage between the write and its effect.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int unsigned SFP_NCH_DEF   = 4;
  localparam int unsigned SFP_DEPTH_DEF = 64;
  localparam int unsigned SFP_DW_DEF    = 32;
endpackage

// File: rtl/sfp_mem.sv
module sfp_mem #(
  parameter int unsigned DEPTH = sfp_pkg::SFP_DEPTH_DEF,
  parameter int unsigned DW    = sfp_pkg::SFP_DW_DEF,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sfp_chan.sv
module sfp_chan #(
  parameter int unsigned DEPTH = sfp_pkg::SFP_DEPTH_DEF,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned SW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic          cfg_en_i,
  input  logic [AW-1:0] cfg_base_i,
  input  logic [SW-1:0] cfg_size_i,
  input  logic          push_i,
  input  logic          pop_i,
  output logic          push_ok_o,
  output logic          pop_ok_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [SW-1:0] level_o,
  output logic          err_o,
  output logic          wr_stb_o,
  output logic          rd_stb_o
);
  logic          en_q, err_q, wstb_q, rstb_q;
  logic [AW-1:0] base_q, wptr_q, rptr_q;
  logic [SW-1:0] size_q, cnt_q;
  logic          load, flush;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p, input logic [SW-1:0] sz);
    return ({1'b0, p} == sz - 1'b1) ? '0 : p + 1'b1;
  endfunction

  // load: new slice accepted; flush: pointers cleared (load or disable)
  assign load    = cfg_we_i && !en_q;
  assign flush   = cfg_we_i && (!en_q || !cfg_en_i);
  assign full_o  = en_q && (cnt_q == size_q);
  assign empty_o = (cnt_q == '0);

  assign push_ok_o = push_i && en_q && !full_o  && !flush;
  assign pop_ok_o  = pop_i  && en_q && !empty_o && !flush;
  assign wr_addr_o = base_q + wptr_q;
  assign rd_addr_o = base_q + rptr_q;
  assign level_o   = cnt_q;
  assign err_o     = err_q;
  assign wr_stb_o  = wstb_q;
  assign rd_stb_o  = rstb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      err_q  <= 1'b0;
      wstb_q <= 1'b0;
      rstb_q <= 1'b0;
      base_q <= '0;
      size_q <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wstb_q <= push_ok_o;
      rstb_q <= pop_ok_o;
      if (flush) begin
        wptr_q <= '0;
        rptr_q <= '0;
        cnt_q  <= '0;
        if (load) begin
          base_q <= cfg_base_i;
          size_q <= cfg_size_i;
          en_q   <= cfg_en_i && (cfg_size_i != '0);
          err_q  <= 1'b0;
        end else begin
          en_q <= 1'b0;
        end
      end else begin
        if (push_ok_o) wptr_q <= bump(wptr_q, size_q);
        if (pop_ok_o)  rptr_q <= bump(rptr_q, size_q);
        cnt_q <= cnt_q + SW'(push_ok_o) - SW'(pop_ok_o);
        if ((push_i && en_q && full_o) || (pop_i && en_q && empty_o)) err_q <= 1'b1;
      end
    end
  end

  p_level_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= size_q);
  p_full_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !cfg_we_i) |=> ($stable(level_o) && err_o));
  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !cfg_we_i) |=> err_o);
  p_wstb_enabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> $past(en_q));
  p_empty_pop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !cfg_we_i) |=> !rd_stb_o);
endmodule

// File: rtl/shared_fifo_part.sv
module shared_fifo_part #(
  parameter int unsigned NCH   = sfp_pkg::SFP_NCH_DEF,
  parameter int unsigned DEPTH = sfp_pkg::SFP_DEPTH_DEF,
  parameter int unsigned DW    = sfp_pkg::SFP_DW_DEF,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned SW   = AW + 1,
  localparam int unsigned CW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CW-1:0]     cfg_ch_i,
  input  logic              cfg_en_i,
  input  logic [AW-1:0]     cfg_base_i,
  input  logic [SW-1:0]     cfg_size_i,
  input  logic              push_i,
  input  logic [CW-1:0]     push_ch_i,
  input  logic [DW-1:0]     push_data_i,
  input  logic              pop_i,
  input  logic [CW-1:0]     pop_ch_i,
  output logic [DW-1:0]     pop_data_o,
  output logic [NCH-1:0]    full_o,
  output logic [NCH-1:0]    empty_o,
  output logic [NCH*SW-1:0] level_o,
  output logic [NCH-1:0]    err_o,
  output logic [NCH-1:0]    wr_stb_o,
  output logic [NCH-1:0]    rd_stb_o
);
  logic [AW-1:0]  wr_addr [NCH];
  logic [AW-1:0]  rd_addr [NCH];
  logic [NCH-1:0] push_ok, pop_ok;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    sfp_chan #(.DEPTH(DEPTH)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (cfg_we_i && (cfg_ch_i == CW'(g))),
      .cfg_en_i   (cfg_en_i),
      .cfg_base_i (cfg_base_i),
      .cfg_size_i (cfg_size_i),
      .push_i     (push_i && (push_ch_i == CW'(g))),
      .pop_i      (pop_i && (pop_ch_i == CW'(g))),
      .push_ok_o  (push_ok[g]),
      .pop_ok_o   (pop_ok[g]),
      .wr_addr_o  (wr_addr[g]),
      .rd_addr_o  (rd_addr[g]),
      .full_o     (full_o[g]),
      .empty_o    (empty_o[g]),
      .level_o    (level_o[g*SW +: SW]),
      .err_o      (err_o[g]),
      .wr_stb_o   (wr_stb_o[g]),
      .rd_stb_o   (rd_stb_o[g])
    );
  end

  sfp_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (|push_ok),
    .waddr_i (wr_addr[push_ch_i]),
    .wdata_i (push_data_i),
    .raddr_i (rd_addr[pop_ch_i]),
    .rdata_o (pop_data_o)
  );

  // single push and pop port: at most one strobe of each kind per cycle
  p_one_wstb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(wr_stb_o));
  p_one_rstb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(rd_stb_o));
endmodule

// File: tb/sim_shared_fifo_part.sv
`timescale 1ns/1ps
module sim_shared_fifo_part;
  localparam int SW = 7;
  localparam int VN = 14;

  typedef struct packed {
    logic        push;
    logic        pop;
    logic [1:0]  ch;
    logic [31:0] data;
    logic [6:0]  lvl;
  } vec_t;

  // ch0 slice 0..3, ch1 slice 4..6, ch2 slice 10..17
  localparam vec_t VEC [VN] = '{
    '{1'b1, 1'b0, 2'd0, 32'hA000_0000, 7'd1},
    '{1'b1, 1'b0, 2'd0, 32'hA000_0001, 7'd2},
    '{1'b1, 1'b0, 2'd1, 32'hB000_0000, 7'd1},
    '{1'b0, 1'b1, 2'd0, 32'hA000_0000, 7'd1},
    '{1'b1, 1'b0, 2'd0, 32'hA000_0002, 7'd2},
    '{1'b1, 1'b0, 2'd0, 32'hA000_0003, 7'd3},
    '{1'b1, 1'b0, 2'd0, 32'hA000_0004, 7'd4},
    '{1'b0, 1'b1, 2'd0, 32'hA000_0001, 7'd3},
    '{1'b0, 1'b1, 2'd0, 32'hA000_0002, 7'd2},
    '{1'b0, 1'b1, 2'd0, 32'hA000_0003, 7'd1},
    '{1'b0, 1'b1, 2'd0, 32'hA000_0004, 7'd0},
    '{1'b0, 1'b1, 2'd1, 32'hB000_0000, 7'd0},
    '{1'b1, 1'b0, 2'd2, 32'hC000_0000, 7'd1},
    '{1'b0, 1'b1, 2'd2, 32'hC000_0000, 7'd0}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0, cfg_en_i = 1'b0;
  logic [1:0]  cfg_ch_i = '0;
  logic [5:0]  cfg_base_i = '0;
  logic [6:0]  cfg_size_i = '0;
  logic        push_i = 1'b0, pop_i = 1'b0;
  logic [1:0]  push_ch_i = '0, pop_ch_i = '0;
  logic [31:0] push_data_i = '0;
  logic [31:0] pop_data_o;
  logic [3:0]  full_o, empty_o, err_o, wr_stb_o, rd_stb_o;
  logic [27:0] level_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] pd;

  always #2 clk = ~clk;

  shared_fifo_part u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we_i), .cfg_ch_i(cfg_ch_i), .cfg_en_i(cfg_en_i),
    .cfg_base_i(cfg_base_i), .cfg_size_i(cfg_size_i),
    .push_i(push_i), .push_ch_i(push_ch_i), .push_data_i(push_data_i),
    .pop_i(pop_i), .pop_ch_i(pop_ch_i), .pop_data_o(pop_data_o),
    .full_o(full_o), .empty_o(empty_o), .level_o(level_o), .err_o(err_o),
    .wr_stb_o(wr_stb_o), .rd_stb_o(rd_stb_o)
  );

  function automatic logic [6:0] lvl(input int c);
    return level_o[c*SW +: SW];
  endfunction

  task automatic chk(input string r, input logic [63:0] a, input logic [63:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, a, e);
    end
  endtask

  task automatic cfg(input logic [1:0] c, input logic [5:0] b, input logic [6:0] s, input logic en);
    cfg_we_i = 1'b1; cfg_ch_i = c; cfg_base_i = b; cfg_size_i = s; cfg_en_i = en;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  // call at a negedge; pop data captured before the edge, registered outputs after
  task automatic step(input logic pu, input logic po, input logic [1:0] c,
                      input logic [31:0] d, output logic [31:0] q);
    push_i = pu; pop_i = po; push_ch_i = c; pop_ch_i = c; push_data_i = d;
    #1 q = pop_data_o;
    @(negedge clk);
    push_i = 1'b0; pop_i = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 empty", 64'(empty_o), 64'hF);
    chk("R1 full", 64'(full_o), 64'h0);
    chk("R1 level", 64'(level_o), 64'h0);
    chk("R1 err/stb", 64'({err_o, wr_stb_o, rd_stb_o}), 64'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    cfg(2'd0, 6'd0, 7'd4, 1'b1);
    cfg(2'd1, 6'd4, 7'd3, 1'b1);
    cfg(2'd2, 6'd10, 7'd8, 1'b1);
    cfg(2'd3, 6'd20, 7'd0, 1'b1);
    chk("R2 empty after cfg", 64'(empty_o), 64'hF);
    chk("R2 full after cfg", 64'(full_o), 64'h0);

    for (int i = 0; i < VN; i++) begin
      step(VEC[i].push, VEC[i].pop, VEC[i].ch, VEC[i].data, pd);
      if (VEC[i].pop) chk("R4/R5 pop order", 64'(pd), 64'(VEC[i].data));
      chk("R6 level", 64'(lvl(int'(VEC[i].ch))), 64'(VEC[i].lvl));
      chk("R8 wr_stb", 64'(wr_stb_o), 64'(VEC[i].push) << VEC[i].ch);
      chk("R8 rd_stb", 64'(rd_stb_o), 64'(VEC[i].pop) << VEC[i].ch);
    end

    // zero-length enable keeps ch3 disabled; traffic there is dropped silently
    step(1'b1, 1'b0, 2'd3, 32'hDEAD_0003, pd);
    chk("R2/R9 ch3 level", 64'(lvl(3)), 64'd0);
    chk("R9 ch3 no strobe", 64'(wr_stb_o), 64'h0);
    chk("R9 ch3 no err", 64'(err_o[3]), 64'd0);
    step(1'b0, 1'b1, 2'd3, 32'h0, pd);
    chk("R9 ch3 pop no strobe/err", 64'({rd_stb_o[3], err_o[3]}), 64'd0);

    // fill ch1 (length 3), then overflow
    step(1'b1, 1'b0, 2'd1, 32'hD000_0000, pd);
    step(1'b1, 1'b0, 2'd1, 32'hD000_0001, pd);
    step(1'b1, 1'b0, 2'd1, 32'hD000_0002, pd);
    chk("R6 ch1 full", 64'(full_o[1]), 64'd1);
    chk("R6 ch1 level", 64'(lvl(1)), 64'd3);
    step(1'b1, 1'b0, 2'd1, 32'hD000_0003, pd);
    chk("R7 overflow level kept", 64'(lvl(1)), 64'd3);
    chk("R7 overflow err", 64'(err_o[1]), 64'd1);
    chk("R8 no strobe on drop", 64'(wr_stb_o), 64'h0);

    step(1'b0, 1'b1, 2'd2, 32'h0, pd);
    chk("R7 underflow err", 64'(err_o[2]), 64'd1);
    chk("R8 no rd strobe on drop", 64'(rd_stb_o), 64'h0);
    chk("R7 err sticky", 64'(err_o[1]), 64'd1);

    // write to enabled ch1 with enable held: slice unchanged
    cfg(2'd1, 6'd30, 7'd8, 1'b1);
    chk("R3 level kept", 64'(lvl(1)), 64'd3);
    chk("R3 still full", 64'(full_o[1]), 64'd1);
    chk("R7 err not cleared", 64'(err_o[1]), 64'd1);
    step(1'b0, 1'b1, 2'd1, 32'h0, pd);
    chk("R3/R5 data from old slice", 64'(pd), 64'hD000_0000);
    chk("R6 level after pop", 64'(lvl(1)), 64'd2);

    cfg(2'd1, 6'd0, 7'd0, 1'b0);
    chk("R3 disable flush level", 64'(lvl(1)), 64'd0);
    chk("R3 disable empty", 64'(empty_o[1]), 64'd1);
    cfg(2'd1, 6'd4, 7'd3, 1'b1);
    chk("R2 reload clears err", 64'(err_o[1]), 64'd0);

    // simultaneous push and pop
    step(1'b1, 1'b0, 2'd2, 32'hE000_0000, pd);
    step(1'b1, 1'b1, 2'd2, 32'hE000_0001, pd);
    chk("R10 pop data", 64'(pd), 64'hE000_0000);
    chk("R10 level unchanged", 64'(lvl(2)), 64'd1);
    chk("R10 both strobes", 64'({wr_stb_o[2], rd_stb_o[2]}), 64'b11);
    step(1'b0, 1'b1, 2'd2, 32'h0, pd);
    chk("R10 second word", 64'(pd), 64'hE000_0001);
    @(negedge clk);
    chk("R8 strobe one cycle", 64'(rd_stb_o), 64'h0);

    // channel independence
    step(1'b1, 1'b0, 2'd0, 32'hF000_0000, pd);
    for (int k = 0; k < 8; k++) step(1'b1, 1'b0, 2'd2, 32'h6000_0000 + k, pd);
    chk("R6 ch2 full", 64'(full_o[2]), 64'd1);
    chk("R6 ch2 level", 64'(lvl(2)), 64'd8);
    step(1'b0, 1'b1, 2'd0, 32'h0, pd);
    chk("R5 ch0 untouched", 64'(pd), 64'hF000_0000);
    for (int k = 0; k < 8; k++) begin
      step(1'b0, 1'b1, 2'd2, 32'h0, pd);
      chk("R5 ch2 wrap order", 64'(pd), 64'(32'h6000_0000 + k));
    end
    chk("R6 ch2 empty", 64'(empty_o[2]), 64'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule